// File: doc/BRIEF.md
# Pseudo-Random Pattern and Signature Self-Test Engine

This block runs a built-in self-test on a purely combinational circuit under test. A 16-bit maximal-length shift register with XOR feedback produces a new non-zero stimulus word in every clock cycle. The word drives the circuit's inputs. In the same cycle, a second 16-bit register with XOR feedback folds the circuit's 16 parallel outputs into a running signature.

After a fixed number of cycles the run stops and the signature freezes. The engine then compares it with a fault-free reference signature that was captured when the run began, and reports pass or fail. A pulse on `start_i` begins a run. The `done_o` flag stays high until the requester acknowledges it, and `start_i` has no effect until that acknowledge arrives.

Top module: `lfsr_bist_engine`

## Requirements
- R1: While reset is held and after it is released with no start, `done_o` and `pass_o` are 0 and `pattern_o` equals the seed (default 16'h0001).
- R2: Consider a start accepted at a clock edge in the idle state. In the cycle after that edge, `pattern_o` equals the seed. The signature is cleared to zero and `golden_i` is captured.
- R3: During a run, each clock edge advances `pattern_o` from p to {fb, p[15:1]}, where fb = p[0]^p[1]^p[3]^p[12]. These taps realise x^16+x^15+x^13+x^4+1.
- R4: `pattern_o` is never zero. Within one full run, the seed does not reappear after the first pattern, so 65,535 distinct patterns are applied.
- R5: At each run edge the signature s becomes {s[14:0],0} ^ (s[15] ? 16'hA011 : 0) ^ `response_i`. The response is sampled in the same cycle as the pattern that produced it.
- R6: `done_o` rises exactly RUN_LEN (default 65,535) cycles after the first pattern cycle.
- R7: When `done_o` is high, `pass_o` is 1 only if the final signature equals the captured golden value. `pass_o` is 0 whenever `done_o` is 0.
- R8: `start_i` is ignored while a run is in progress and while `done_o` is high. In both cases `done_o` and `pattern_o` continue as if no start had occurred, and `pattern_o` holds its value while done.
- R9: While done, `ack_i` returns the engine to idle on the next edge and clears `done_o` and `pass_o`. A following start then begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| ack_i | input | 1 | Acknowledge done, return to idle |
| golden_i | input | 16 | Fault-free reference signature, captured at start |
| response_i | input | 16 | Outputs of the circuit under test |
| pattern_o | output | 16 | Stimulus word to the circuit under test |
| done_o | output | 1 | Run finished, signature frozen |
| pass_o | output | 1 | Signature matches reference (valid with done) |

## Verification
The assertions assume three things about the inputs. First, `response_i` is a function of the current `pattern_o` alone and settles within the cycle. Second, `golden_i` is valid in the cycle in which start is taken. Third, `ack_i` only matters while done. The bench drives all inputs at the falling edge. It models the circuit under test as a continuous assignment from `pattern_o`, which keeps the response combinational and in step with the pattern. A fault is injected by flipping one response bit on a single pattern, which leaves the fault-free reference unchanged and so must produce a fail.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bist_state_e;
endpackage

// File: rtl/bist_prpg.sv
module bist_prpg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'h100B,
  parameter logic [W-1:0] SEED = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] pat_o
);
  logic [W-1:0] lfsr_q;
  logic         fb;

  // Right shift, feedback enters at MSB
  assign fb = ^(lfsr_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (load_i) lfsr_q <= SEED;
    else if (step_i) lfsr_q <= {fb, lfsr_q[W-1:1]};
  end

  assign pat_o = lfsr_q;

  AST_PRPG_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R4
  AST_PRPG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(lfsr_q)); // R8
  AST_PRPG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> lfsr_q == SEED); // R2
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'hA011
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;
  logic         msb;

  assign msb = sig_q[W-1];

  // Galois stages, each absorbing one response bit
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sig_d[i] = (msb & POLY[i]) ^ resp_i[i];
    end else begin : g_rest
      assign sig_d[i] = sig_q[i-1] ^ (msb & POLY[i]) ^ resp_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sig_q <= '0;
    else if (clear_i) sig_q <= '0;
    else if (en_i)    sig_q <= sig_d;
  end

  assign sig_o = sig_q;

  AST_MISR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> sig_q == '0); // R2
  AST_MISR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !en_i) |=> $stable(sig_q)); // R5
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl #(
  parameter int W       = 16,
  parameter int RUN_LEN = 65535
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         ack_i,
  input  logic [W-1:0] golden_i,
  output logic         load_o,
  output logic         run_o,
  output logic         done_o,
  output logic [W-1:0] golden_o
);
  import bist_pkg::*;

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  bist_state_e  state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0] golden_q;
  logic         last;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign last   = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      golden_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_RUN;
          cnt_q    <= '0;
          golden_q <= golden_i;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) state_q <= ST_DONE;
        end
        ST_DONE: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign golden_o = golden_q;

  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && last) |=> done_o); // R6
  AST_NO_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last) |=> run_o); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> done_o); // R8
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ack_i) |=> !done_o && !run_o); // R9
endmodule

// File: rtl/lfsr_bist_engine.sv
module lfsr_bist_engine #(
  parameter int           W       = 16,
  parameter logic [W-1:0] TAPS    = 16'h100B,
  parameter logic [W-1:0] POLY    = 16'hA011,
  parameter logic [W-1:0] SEED    = 16'h0001,
  parameter int           RUN_LEN = 65535
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         ack_i,
  input  logic [W-1:0] golden_i,
  input  logic [W-1:0] response_i,
  output logic [W-1:0] pattern_o,
  output logic         done_o,
  output logic         pass_o
);
  logic         load, run, done;
  logic [W-1:0] sig, golden;

  bist_ctrl #(.W(W), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .ack_i, .golden_i,
    .load_o(load), .run_o(run), .done_o(done), .golden_o(golden)
  );

  bist_prpg #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_prpg (
    .clk_i, .rst_ni, .load_i(load), .step_i(run), .pat_o(pattern_o)
  );

  bist_misr #(.W(W), .POLY(POLY)) u_misr (
    .clk_i, .rst_ni, .clear_i(load), .en_i(run),
    .resp_i(response_i), .sig_o(sig)
  );

  assign done_o = done;
  assign pass_o = done && (sig == golden);

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o); // R7
  AST_PASS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(pass_o)); // R7
endmodule

// File: tb/lfsr_bist_engine_test.sv
`timescale 1ns/1ps
module lfsr_bist_engine_test;
  localparam int RUN_LEN = 65535;
  localparam logic [15:0] SEED = 16'h0001;
  localparam logic [15:0] FAULT_PAT = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ack = 1'b0, fault_en = 1'b0;
  logic [15:0] golden = '0;
  logic [15:0] pattern, response;
  logic done, pass;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] cut(input logic [15:0] p);
    return {p[6:0], p[15:7]} ^ (p >> 3) ^ 16'h5A3C;
  endfunction

  // Combinational circuit under test, with an optional single-bit fault
  assign response = cut(pattern) ^ ((fault_en && pattern == FAULT_PAT) ? 16'h0020 : 16'h0000);

  function automatic logic [15:0] fib(input logic [15:0] p);
    return {p[0] ^ p[1] ^ p[3] ^ p[12], p[15:1]};
  endfunction

  function automatic logic [15:0] mstep(input logic [15:0] s, input logic [15:0] r);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'hA011 : 16'h0000) ^ r;
  endfunction

  function automatic logic [15:0] ref_sig();
    logic [15:0] p = SEED, s = '0;
    for (int k = 0; k < RUN_LEN; k++) begin
      s = mstep(s, cut(p));
      p = fib(p);
    end
    return s;
  endfunction

  lfsr_bist_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ack_i(ack),
    .golden_i(golden), .response_i(response),
    .pattern_o(pattern), .done_o(done), .pass_o(pass)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0 && pass == 1'b0, "R1 flags in reset", {done, pass}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && pass == 1'b0, "R1 flags idle", {done, pass}, 0);
    check(pattern == SEED, "R1 seed after reset", pattern, SEED);
  endtask

  // One full run; mid_start pulses start during the run
  task automatic t_run(input logic [15:0] gold, input bit fault, input bit mid_start, input bit exp_pass);
    logic [15:0] mp = SEED;
    int seq_err = 0, zero_err = 0, seed_err = 0, done_err = 0;
    logic [15:0] bad_act = '0, bad_exp = '0;
    golden = gold; fault_en = fault;
    start = 1'b1;
    @(negedge clk); start = 1'b0; golden = ~gold;
    check(pattern == SEED, "R2 seed on start", pattern, SEED);
    for (int k = 0; k < RUN_LEN; k++) begin
      if (mid_start) start = (k == 100 || k == 40000);
      if (pattern != mp) begin
        if (seq_err == 0) begin bad_act = pattern; bad_exp = mp; end
        seq_err++;
      end
      if (pattern == 16'h0) zero_err++;
      if (k > 0 && pattern == SEED) seed_err++;
      if (done) done_err++;
      mp = fib(mp);
      @(negedge clk);
    end
    start = 1'b0;
    check(seq_err == 0, mid_start ? "R8 start ignored in run" : "R3 pattern sequence", bad_act, bad_exp);
    check(zero_err == 0 && seed_err == 0, "R4 nonzero distinct patterns", zero_err + seed_err, 0);
    check(done_err == 0, "R6 no early done", done_err, 0);
    check(done == 1'b1, "R6 done after RUN_LEN", done, 1);
    check(pass == exp_pass, exp_pass ? "R5 R7 signature pass" : "R7 fault detected", pass, exp_pass);
    fault_en = 1'b0;
  endtask

  task automatic t_done_hold();
    logic [15:0] p0 = pattern;
    logic pa0 = pass;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 start ignored while done", done, 1);
    check(pattern == p0, "R8 pattern holds while done", pattern, p0);
    check(pass == pa0, "R7 pass stable while done", pass, pa0);
  endtask

  task automatic t_ack();
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check(done == 1'b0 && pass == 1'b0, "R9 ack clears done", {done, pass}, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 idle after ack", done, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] good_sig;
    good_sig = ref_sig();
    repeat (2) @(negedge clk);
    t_reset();
    t_run(good_sig, 1'b0, 1'b0, 1'b1);
    t_done_hold();
    t_ack();
    t_run(good_sig, 1'b1, 1'b1, 1'b0);
    t_ack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule